// File: doc/BRIEF.md
# Serial Memory Write-Protect and Status Unit

This block keeps the eight-bit status byte of a serial memory and its write enable latch. It decides, in the same cycle, whether a requested array-byte write or status-register write is granted or denied. A serial front end outside this block decodes commands. It hands the block single-cycle strobes: latch set, latch clear, flag set, flag clear, a status write with its data byte and an array write with its address. The block also takes the external active-low write-protect pin and a pulse from the memory core that marks the end of an internal write.

A granted request starts an internal write cycle. The busy bit reads 1 until the completion pulse arrives, and that pulse also drops the latch. The nonvolatile status fields are emulated with flops and cleared by the power-on reset. The array is split into a lockable upper region, sized by the two lock bits, and a lower region that stays writable whenever the latch is set.

Top module: `wprot_status`

## Requirements
- R1: After power-on reset the status byte reads 0x00. Bit order from bit 7 to bit 0 is: WPEN, FLB, WD1, WD0, BL1, BL0, WEL, WIP.
- R2: `wel_set` sets WEL (bit 1) and `wel_clr` clears it, visible one cycle later. When both are strobed together, the clear wins.
- R3: While WEL is 0, every status and array write request is denied and WIP stays 0.
- R4: With WEL at 1 and no write in progress, a status write is granted when WPEN is 0 (whatever the pin) or when `wp_n` is high.
- R5: With WPEN at 1 and `wp_n` low, a status write is denied and the status byte is unchanged.
- R6: A granted status write loads bits 7, 5, 4, 3 and 2 from the data byte. FLB, WEL and WIP are never taken from the data.
- R7: BL1:BL0 selects the locked array range: 00 locks nothing, 01 locks the top quarter of the address space, 10 the top half and 11 the whole array. An array write inside the locked range is always denied. Outside it, the write is granted when WEL is 1 and the unit is idle.
- R8: A grant sets WIP (bit 0) on the next cycle. While WIP is 1, every write request is denied.
- R9: A `wr_done` pulse while WIP is 1 clears both WIP and WEL on the next cycle. A `wr_done` pulse while WIP is 0 has no effect.
- R10: `flag_set` sets FLB (bit 6) and `flag_clr` clears it. The clear wins when both are strobed together.
- R11: A denied request starts no write cycle (WIP stays 0) and leaves WEL unchanged.
- R12: Each request gets exactly one of grant or deny in its cycle. When both requests arrive together, the status request takes precedence and the array request is denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| wel_set | input | 1 | Set-latch command strobe |
| wel_clr | input | 1 | Clear-latch command strobe |
| flag_set | input | 1 | Set-flag command strobe |
| flag_clr | input | 1 | Clear-flag command strobe |
| sr_wr_req | input | 1 | Status write request |
| sr_wr_data | input | 8 | Data byte of the status write |
| arr_wr_req | input | 1 | Array byte write request |
| arr_wr_addr | input | ADDR_W | Target byte address of the array write |
| wp_n | input | 1 | External write-protect pin, active low |
| wr_done | input | 1 | End-of-internal-write pulse |
| status | output | 8 | Status byte for reads |
| sr_wr_grant | output | 1 | Status write granted |
| sr_wr_deny | output | 1 | Status write refused |
| arr_wr_grant | output | 1 | Array write granted |
| arr_wr_deny | output | 1 | Array write refused |

## Verification
The bench builds the unit with ADDR_W = 4, which gives a 16-byte array. At that size the quarter and half lock boundaries fall at addresses 12 and 8. Every address can then be tried under each of the four lock codes, with the expected grant computed from the address arithmetic. The small width also leaves room for a full sweep of WPEN against the pin level on status writes, and for the busy, completion and priority corner cases around each grant.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
   typedef struct packed {
      logic       wpen;
      logic       flb;
      logic [1:0] wd;
      logic [1:0] bl;
      logic       wel;
      logic       wip;
   } status_t;

   localparam status_t STATUS_RST = '0;
   localparam logic [7:0] SR_DATA_MASK = 8'b1011_1100;
endpackage

// File: rtl/wprot_region.sv
module wprot_region #(
   parameter int ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        lock_code,
   output logic              locked
);
   localparam int unsigned DEPTH = 1 << ADDR_W;
   localparam int unsigned QUART = DEPTH / 4;

   logic [3:0] in_range;

   if (ADDR_W < 2) begin : g_bad_width
      $error("wprot_region: ADDR_W must be at least 2");
   end

   assign in_range[0] = 1'b0;

   for (genvar k = 1; k < 4; k++) begin : g_code
      localparam int unsigned LOW = (k == 3) ? 0 : DEPTH - k * QUART;
      localparam logic [ADDR_W:0] LOW_V = LOW[ADDR_W:0];
      assign in_range[k] = ({1'b0, addr} >= LOW_V);
   end

   assign locked = in_range[lock_code];
endmodule

// File: rtl/wprot_arbiter.sv
module wprot_arbiter (
   input  logic sr_req,
   input  logic arr_req,
   input  logic addr_locked,
   input  logic wel,
   input  logic wip,
   input  logic wpen,
   input  logic wp_n,
   output logic sr_grant,
   output logic sr_deny,
   output logic arr_grant,
   output logic arr_deny
);
   logic ready;
   logic sr_ok;
   logic arr_ok;

   always_comb begin
      ready  = wel & ~wip;
      sr_ok  = ready & (~wpen | wp_n);
      arr_ok = ready & ~addr_locked & ~sr_req;
   end

   assign sr_grant  = sr_req & sr_ok;
   assign sr_deny   = sr_req & ~sr_ok;
   assign arr_grant = arr_req & arr_ok;
   assign arr_deny  = arr_req & ~arr_ok;
endmodule

// File: rtl/wprot_regs.sv
module wprot_regs
   import wprot_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wel_set,
   input  logic       wel_clr,
   input  logic       flag_set,
   input  logic       flag_clr,
   input  logic       load_sr,
   input  logic [7:0] sr_data,
   input  logic       start_wr,
   input  logic       wr_done,
   output status_t    sr_q
);
   status_t sr_d;
   status_t wr_img;
   logic    finish;

   always_comb begin
      wr_img = status_t'(sr_data & SR_DATA_MASK);
      finish = wr_done & sr_q.wip;
      sr_d   = sr_q;

      if (load_sr) begin
         sr_d.wpen = wr_img.wpen;
         sr_d.wd   = wr_img.wd;
         sr_d.bl   = wr_img.bl;
      end

      if (flag_clr)      sr_d.flb = 1'b0;
      else if (flag_set) sr_d.flb = 1'b1;

      if (finish)       sr_d.wel = 1'b0;
      else if (wel_clr) sr_d.wel = 1'b0;
      else if (wel_set) sr_d.wel = 1'b1;

      if (start_wr)    sr_d.wip = 1'b1;
      else if (finish) sr_d.wip = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr_q <= STATUS_RST;
      else        sr_q <= sr_d;
   end
endmodule

// File: rtl/wprot_status.sv
module wprot_status
   import wprot_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wel_set,
   input  logic              wel_clr,
   input  logic              flag_set,
   input  logic              flag_clr,
   input  logic              sr_wr_req,
   input  logic [7:0]        sr_wr_data,
   input  logic              arr_wr_req,
   input  logic [ADDR_W-1:0] arr_wr_addr,
   input  logic              wp_n,
   input  logic              wr_done,
   output logic [7:0]        status,
   output logic              sr_wr_grant,
   output logic              sr_wr_deny,
   output logic              arr_wr_grant,
   output logic              arr_wr_deny
);
   status_t sr_q;
   logic    locked;

   wprot_region #(.ADDR_W(ADDR_W)) u_region (
      .addr      (arr_wr_addr),
      .lock_code (sr_q.bl),
      .locked    (locked)
   );

   wprot_arbiter u_arb (
      .sr_req      (sr_wr_req),
      .arr_req     (arr_wr_req),
      .addr_locked (locked),
      .wel         (sr_q.wel),
      .wip         (sr_q.wip),
      .wpen        (sr_q.wpen),
      .wp_n        (wp_n),
      .sr_grant    (sr_wr_grant),
      .sr_deny     (sr_wr_deny),
      .arr_grant   (arr_wr_grant),
      .arr_deny    (arr_wr_deny)
   );

   wprot_regs u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wel_set  (wel_set),
      .wel_clr  (wel_clr),
      .flag_set (flag_set),
      .flag_clr (flag_clr),
      .load_sr  (sr_wr_grant),
      .sr_data  (sr_wr_data),
      .start_wr (sr_wr_grant | arr_wr_grant),
      .wr_done  (wr_done),
      .sr_q     (sr_q)
   );

   assign status = sr_q;
endmodule

// File: rtl/wprot_status_sva.sv
module wprot_status_sva #(
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wel_set,
   input logic              wel_clr,
   input logic              flag_set,
   input logic              flag_clr,
   input logic              sr_wr_req,
   input logic [7:0]        sr_wr_data,
   input logic              arr_wr_req,
   input logic [ADDR_W-1:0] arr_wr_addr,
   input logic              wp_n,
   input logic              wr_done,
   input logic [7:0]        status,
   input logic              sr_wr_grant,
   input logic              sr_wr_deny,
   input logic              arr_wr_grant,
   input logic              arr_wr_deny
);
   AST_SR_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
      sr_wr_req |-> (sr_wr_grant ^ sr_wr_deny)); // R12
   AST_ARR_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
      arr_wr_req |-> (arr_wr_grant ^ arr_wr_deny)); // R12
   AST_NO_GRANT_WITHOUT_WEL: assert property (@(posedge clk) disable iff (!rst_n)
      !status[1] |-> !(sr_wr_grant || arr_wr_grant)); // R3
   AST_SR_PROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_wr_req && status[7] && !wp_n) |-> !sr_wr_grant); // R5
   AST_FULL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_wr_req && status[3:2] == 2'b11) |-> !arr_wr_grant); // R7
   AST_GRANT_SETS_WIP: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_wr_grant || arr_wr_grant) |=> status[0]); // R8
   AST_BUSY_DENIES: assert property (@(posedge clk) disable iff (!rst_n)
      status[0] |-> !(sr_wr_grant || arr_wr_grant)); // R8
   AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_done && status[0]) |=> (status[1:0] == 2'b00)); // R9
   AST_FLB_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_set && !flag_clr) |=> (status[6] == $past(status[6]))); // R6
   AST_DENY_KEEPS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
      ((sr_wr_deny || arr_wr_deny) && !wel_set && !wel_clr && !(wr_done && status[0]))
      |=> (status[1] == $past(status[1]))); // R11
endmodule

bind wprot_status wprot_status_sva #(.ADDR_W(ADDR_W)) u_sva (.*);

// File: tb/wprot_status_tb.sv
module wprot_status_tb;
   localparam int ADDR_W = 4;
   localparam int DEPTH  = 1 << ADDR_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wel_set = 1'b0, wel_clr = 1'b0;
   logic              flag_set = 1'b0, flag_clr = 1'b0;
   logic              sr_wr_req = 1'b0, arr_wr_req = 1'b0;
   logic [7:0]        sr_wr_data = '0;
   logic [ADDR_W-1:0] arr_wr_addr = '0;
   logic              wp_n = 1'b1, wr_done = 1'b0;
   logic [7:0]        status;
   logic              sr_wr_grant, sr_wr_deny, arr_wr_grant, arr_wr_deny;

   int n_tests = 0;
   int n_fail  = 0;
   logic s_g, s_d, a_g, a_d;

   always #4 clk = ~clk;

   wprot_status #(.ADDR_W(ADDR_W)) u_dut (.*);

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input logic ws, input logic wc, input logic fs, input logic fc,
                      input logic sr, input logic [7:0] d, input logic ar,
                      input logic [ADDR_W-1:0] a, input logic dn);
      @(negedge clk);
      wel_set = ws; wel_clr = wc; flag_set = fs; flag_clr = fc;
      sr_wr_req = sr; sr_wr_data = d; arr_wr_req = ar; arr_wr_addr = a; wr_done = dn;
      #1;
      s_g = sr_wr_grant; s_d = sr_wr_deny; a_g = arr_wr_grant; a_d = arr_wr_deny;
      @(posedge clk); #1;
      wel_set = 0; wel_clr = 0; flag_set = 0; flag_clr = 0;
      sr_wr_req = 0; arr_wr_req = 0; wr_done = 0;
   endtask

   task automatic idle();              cyc(0,0,0,0,0,8'h00,0,'0,0); endtask
   task automatic set_wel();           cyc(1,0,0,0,0,8'h00,0,'0,0); endtask
   task automatic clr_wel();           cyc(0,1,0,0,0,8'h00,0,'0,0); endtask
   task automatic done();              cyc(0,0,0,0,0,8'h00,0,'0,1); endtask
   task automatic sr_write(input logic [7:0] d); cyc(0,0,0,0,1,d,0,'0,0); endtask

   task automatic program_sr(input logic [7:0] d);
      set_wel(); sr_write(d); done();
   endtask

   function automatic bit is_locked(input int bl, input int a);
      case (bl)
         1: return a >= (DEPTH * 3) / 4;
         2: return a >= DEPTH / 2;
         3: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #1 chk(status == 8'h00, "R1 reset status", status, 8'h00);

      // R3: no latch, every request denied
      for (int a = 0; a < DEPTH; a++) begin
         cyc(0,0,0,0,0,8'h00,1,a[ADDR_W-1:0],0);
         chk(a_d && !a_g && status == 8'h00, "R3 array deny without WEL", {a_g,a_d}, 2'b01);
      end
      sr_write(8'h0C);
      chk(s_d && !s_g && status == 8'h00, "R3 status deny without WEL", status, 8'h00);

      // R2 latch control
      set_wel();
      chk(status == 8'h02, "R2 wel_set", status, 8'h02);
      clr_wel();
      chk(status == 8'h00, "R2 wel_clr", status, 8'h00);
      set_wel();
      cyc(1,1,0,0,0,8'h00,0,'0,0);
      chk(status == 8'h00, "R2 clear wins", status, 8'h00);

      // R10 flag control
      cyc(0,0,1,0,0,8'h00,0,'0,0);
      chk(status == 8'h40, "R10 flag_set", status, 8'h40);
      cyc(0,0,1,1,0,8'h00,0,'0,0);
      chk(status == 8'h00, "R10 flag clear wins", status, 8'h00);

      // R9 done with no write pending is ignored
      set_wel(); done();
      chk(status == 8'h02, "R9 idle done ignored", status, 8'h02);
      clr_wel();

      // R7/R8/R9/R11 region sweep
      for (int bl = 0; bl < 4; bl++) begin
         program_sr(8'(bl << 2));
         chk(status == 8'(bl << 2), "R7 lock code programmed", status, bl << 2);
         for (int a = 0; a < DEPTH; a++) begin
            bit exp_g;
            exp_g = !is_locked(bl, a);
            set_wel();
            cyc(0,0,0,0,0,8'h00,1,a[ADDR_W-1:0],0);
            chk(a_g == exp_g && a_d == !exp_g, "R7 array grant by region", a_g, exp_g);
            if (exp_g) begin
               chk(status[1:0] == 2'b11, "R8 WIP after grant", status[1:0], 2'b11);
               cyc(0,0,0,0,1,8'h00,1,a[ADDR_W-1:0],0);
               chk(!a_g && !s_g && a_d && s_d, "R8 busy denies", {s_g,a_g}, 0);
               done();
               chk(status[1:0] == 2'b00, "R9 done clears WIP and WEL", status[1:0], 0);
            end else begin
               chk(status[1:0] == 2'b10, "R11 deny keeps WEL, no WIP", status[1:0], 2'b10);
               clr_wel();
            end
         end
      end
      program_sr(8'h00);

      // R4/R5/R6 status write matrix
      for (int wpen = 0; wpen < 2; wpen++) begin
         for (int wp = 0; wp < 2; wp++) begin
            logic [7:0] d, exp_st;
            bit exp_g;
            wp_n = 1'b1;
            program_sr(wpen ? 8'h80 : 8'h00);
            wp_n = wp[0];
            set_wel();
            d = {wpen[0], 7'b1001111};
            exp_g = (wpen == 0) || (wp == 1);
            sr_write(d);
            exp_st = exp_g ? {wpen[0], 1'b0, 6'b001111} : {wpen[0], 7'b0000010};
            if (exp_g) chk(s_g && !s_d, "R4 status write granted", s_g, 1);
            else       chk(s_d && !s_g, "R5 status write denied", s_d, 1);
            chk(status == exp_st, exp_g ? "R6 written fields only" : "R5 status unchanged",
                status, exp_st);
            if (exp_g) done(); else clr_wel();
            wp_n = 1'b1;
            program_sr(8'h00);
         end
      end

      // R12 simultaneous requests
      set_wel();
      cyc(0,0,0,0,1,8'h20,1,'0,0);
      chk(s_g && !s_d && a_d && !a_g, "R12 status request wins", {s_g,a_g}, 2'b10);
      chk(status == 8'h23, "R12 one write started", status, 8'h23);
      done();
      idle();

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule